// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write an external 2048 x 8 asynchronous static RAM. The RAM is controlled by three active-low strobes (chip select, output gate, write strobe) and exchanges data over one shared bidirectional bus. The host issues one transfer at a time through a valid/ready port that carries an 11-bit word address, a write flag and write data. Read results come back registered, with a one-cycle valid pulse.

Every RAM timing limit is written in nanoseconds and turned into a whole number of clock cycles by elaboration-time functions. The functions take the clock period and a speed-grade parameter (fast: 70 ns access, standard: 90 ns access). The data bus is split at the block edge into an output value, a registered drive enable and an input value, so the pad tristate sits outside. The controller turns its drive on only after the RAM's outputs have had time to float. It turns its drive off only after the data hold time following the write strobe.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high and in the cycle after it, `req_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe` and `rd_valid` are 0.
- R2: A request is taken at a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after that edge and stays 0 until the transfer has finished.
- R3: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 with a steady `mem_addr`, and `mem_dq_oe` stays 0 throughout.
- R4: The byte a read returns on `rd_data` is the byte most recently written to that address; bytes written to the lowest (0) and highest (2047) addresses come back intact.
- R5: Each `mem_we_n` low pulse lasts at least max(pulse width, data setup, address-to-strobe-end minus address setup) cycles, which is 4 cycles at 10 ns for the fast grade. `mem_ce_n` is 0 and `mem_dq_oe` is 1 for the whole pulse.
- R6: `mem_addr` is stable while `mem_we_n` is 0 and for one cycle after it rises, and `mem_ce_n` is 0 for at least one cycle before `mem_we_n` falls.
- R7: `mem_dq_oe` is 1 only while `mem_oe_n` is 1, and only after `mem_oe_n` has been high for at least the output-float time (4 cycles at 10 ns, fast grade). The controller and the RAM never drive the bus at the same time.
- R8: After `mem_we_n` rises, `mem_dq_oe` stays 1 for the hold count (2 cycles, fast grade at 10 ns) and then drops.
- R9: Each limit becomes ceil(ns / period) cycles, never fewer than 1. With the defaults (10 ns clock, fast grade), `rd_valid` rises exactly 7 cycles after the edge that takes a read.
- R10: `rd_valid` is a single-cycle pulse that appears only for reads; writes never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is new |
| mem_addr | output | 11 | RAM address lines |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output gate, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | 8 | Value the controller drives on the data bus |
| mem_dq_oe | output | 1 | Registered drive enable for the data bus |
| mem_dq_in | input | 8 | Value seen on the data bus |

## Verification
On every cycle, the embedded properties enforce the strobe relationships. They check that the write pulse width is at least its minimum, that the address holds still around the write strobe and during reads, that drive appears only after the output gate has been high long enough, and that the valid strobe and the ready handshake behave correctly. Only the bench's scenarios can show that data survives the round trip through a RAM model at boundary and random addresses, that the read latency matches the derived cycle count, and that reads and writes placed back to back in various orders never collide on the bus when measured against the RAM's real float delay in nanoseconds.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD
    } seq_state_e;

    typedef enum logic [3:0] {
        T_ACCESS,
        T_ADDR_SETUP,
        T_WE_WIDTH,
        T_ADDR_TO_WE_END,
        T_DATA_SETUP,
        T_DATA_HOLD,
        T_ADDR_HOLD,
        T_OUT_FLOAT,
        T_CYCLE
    } timing_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
    } strobe_t;

    function automatic int grade_ns(bit fast, timing_e which);
        case (which)
            T_ACCESS:         return fast ? 70 : 90;
            T_ADDR_SETUP:     return 10;
            T_WE_WIDTH:       return fast ? 40 : 55;
            T_ADDR_TO_WE_END: return fast ? 50 : 65;
            T_DATA_SETUP:     return 30;
            T_DATA_HOLD:      return fast ? 10 : 15;
            T_ADDR_HOLD:      return 10;
            T_OUT_FLOAT:      return fast ? 35 : 40;
            default:          return fast ? 70 : 90;
        endcase
    endfunction

    function automatic int ns_to_cycles(int ns, int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobes_for(seq_state_e s);
        case (s)
            ST_READ:   return '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1};
            ST_WSETUP: return '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1};
            ST_WPULSE: return '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0};
            ST_WHOLD:  return '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1};
            default:   return '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};
        endcase
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] remain
);
    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int CW     = 8,
    parameter int ACC_C  = 7,
    parameter int AS_C   = 1,
    parameter int WP_C   = 4,
    parameter int HOLD_C = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          step_last,
    input  logic          drive_q,
    output seq_state_e    st_q,
    output seq_state_e    st_d,
    output logic          tload,
    output logic [CW-1:0] tval,
    output logic          capture,
    output logic          ready
);
    assign ready = (st_q == ST_IDLE);

    always_comb begin
        st_d    = st_q;
        tload   = 1'b0;
        tval    = '0;
        capture = 1'b0;
        case (st_q)
            ST_IDLE: if (req_valid) begin
                tload = 1'b1;
                if (req_write) begin
                    st_d = ST_WSETUP;
                    tval = CW'(AS_C);
                end else begin
                    st_d = ST_READ;
                    tval = CW'(ACC_C);
                end
            end
            ST_READ: if (step_last) begin
                st_d    = ST_IDLE;
                capture = 1'b1;
            end
            ST_WSETUP: if (step_last && drive_q) begin
                st_d  = ST_WPULSE;
                tload = 1'b1;
                tval  = CW'(WP_C);
            end
            ST_WPULSE: if (step_last) begin
                st_d  = ST_WHOLD;
                tload = 1'b1;
                tval  = CW'(HOLD_C);
            end
            ST_WHOLD: if (step_last) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && req_valid) |=> !ready);
endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= din;
        end
    end

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter bit FAST_GRADE    = 1'b1,
    parameter int AW            = 11,
    parameter int DW            = 8,
    parameter int CW            = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int ACC_C = ns_to_cycles(grade_ns(FAST_GRADE, T_ACCESS), CLK_PERIOD_NS);
    localparam int AS_C  = ns_to_cycles(grade_ns(FAST_GRADE, T_ADDR_SETUP), CLK_PERIOD_NS);
    localparam int CYC_C = ns_to_cycles(grade_ns(FAST_GRADE, T_CYCLE), CLK_PERIOD_NS);
    localparam int FL_C  = ns_to_cycles(grade_ns(FAST_GRADE, T_OUT_FLOAT), CLK_PERIOD_NS);
    localparam int WP_C  = imax(imax(ns_to_cycles(grade_ns(FAST_GRADE, T_WE_WIDTH), CLK_PERIOD_NS),
                                     ns_to_cycles(grade_ns(FAST_GRADE, T_DATA_SETUP), CLK_PERIOD_NS)),
                                ns_to_cycles(grade_ns(FAST_GRADE, T_ADDR_TO_WE_END), CLK_PERIOD_NS) - AS_C);
    localparam int HOLD_C = imax(imax(ns_to_cycles(grade_ns(FAST_GRADE, T_DATA_HOLD), CLK_PERIOD_NS),
                                      ns_to_cycles(grade_ns(FAST_GRADE, T_ADDR_HOLD), CLK_PERIOD_NS)),
                                 CYC_C - AS_C - WP_C);
    localparam logic [CW-1:0] CNT_MAX = '1;

    seq_state_e    st_q, st_d;
    strobe_t       pins_q, pins_d;
    logic          tload, capture, drive_q, drive_d, step_last, float_ok, accept;
    logic [CW-1:0] tval, step_rem, float_rem;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    assign accept = req_valid && req_ready;

    sram_ctl_seq #(.CW(CW), .ACC_C(ACC_C), .AS_C(AS_C), .WP_C(WP_C), .HOLD_C(HOLD_C)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .step_last(step_last), .drive_q(drive_q), .st_q(st_q), .st_d(st_d),
        .tload(tload), .tval(tval), .capture(capture), .ready(req_ready)
    );

    sram_ctl_timer #(.CW(CW)) u_step (
        .clk(clk), .rst(rst), .load(tload), .load_val(tval), .remain(step_rem)
    );
    assign step_last = (step_rem <= CW'(1));

    // Output-float timer: restarts whenever the output gate is about to rise.
    sram_ctl_timer #(.CW(CW)) u_float (
        .clk(clk), .rst(rst), .load(pins_d.oe_n && !pins_q.oe_n),
        .load_val(CW'(FL_C)), .remain(float_rem)
    );
    assign float_ok = (float_rem == '0);

    sram_ctl_rdcap #(.DW(DW)) u_rdcap (
        .clk(clk), .rst(rst), .capture(capture), .din(mem_dq_in),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign pins_d  = strobes_for(st_d);
    assign drive_d = (st_d == ST_WPULSE) || (st_d == ST_WHOLD) ||
                     ((st_d == ST_WSETUP) && float_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q  <= '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};
            drive_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            pins_q  <= pins_d;
            drive_q <= drive_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    assign mem_addr   = addr_q;
    assign mem_ce_n   = pins_q.ce_n;
    assign mem_oe_n   = pins_q.oe_n;
    assign mem_we_n   = pins_q.we_n;
    assign mem_dq_out = wdata_q;
    assign mem_dq_oe  = drive_q;

    // Checker counters: write-strobe low length and output-gate high length.
    logic [CW-1:0] we_low_cnt, oe_high_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt  <= '0;
            oe_high_cnt <= CNT_MAX;
        end else begin
            we_low_cnt  <= !mem_we_n ? ((we_low_cnt == CNT_MAX) ? we_low_cnt : we_low_cnt + 1'b1) : '0;
            oe_high_cnt <= mem_oe_n ? ((oe_high_cnt == CNT_MAX) ? oe_high_cnt : oe_high_cnt + 1'b1) : '0;
        end
    end

    // R3
    read_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));
    // R3
    read_addr_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |=> $stable(mem_addr));
    // R5
    we_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_cnt >= CW'(WP_C)));
    // R5
    we_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe));
    // R6
    we_addr_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |=> $stable(mem_addr));
    // R6
    we_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> !$past(mem_ce_n));
    // R7
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n && oe_high_cnt >= CW'(FL_C)));
    // R8
    drive_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dq_oe);
endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
    localparam int PER     = 10;
    localparam int ACC_EXP = (70 + PER - 1) / PER;   // R9: fast grade access
    localparam int WP_EXP  = 4;                       // R5: fast grade pulse cycles
    localparam real FLOAT_NS = 35.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rd_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0] rd_data, mem_dq_out, bus;
    logic [10:0] mem_addr;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sram_ctl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(bus)
    );

    // Behavioural RAM
    logic [7:0] ram [0:2047];
    logic ram_out_en;
    assign ram_out_en = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign bus = mem_dq_oe ? mem_dq_out : (ram_out_en ? ram[mem_addr] : 8'h00);
    always @(posedge mem_we_n) if (!rst && !mem_ce_n) ram[mem_addr] <= bus;
    realtime t_oe_rise = -1000.0;
    always @(posedge mem_oe_n) t_oe_rise = $realtime;

    // Reference model
    logic [7:0] ref_mem [int];
    int   exp_due [$];
    logic [7:0] exp_dat [$];

    task automatic check(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
        end
    endtask

    // Per-cycle comparison
    int we_low = 0;
    bit we_drv_ok = 1;
    always @(negedge clk) if (!rst) begin
        if (exp_due.size() > 0 && exp_due[0] == cyc) begin
            check(rd_valid == 1'b1, "R9 read latency", rd_valid, 1);
            check(rd_data == exp_dat[0], "R4 read data", rd_data, exp_dat[0]);
            void'(exp_due.pop_front());
            void'(exp_dat.pop_front());
        end else if (rd_valid) begin
            check(1'b0, "R10 unexpected rd_valid", 1, 0);
        end
        if (mem_dq_oe) begin
            bit ram_busy;
            ram_busy = ram_out_en || (($realtime - t_oe_rise) < FLOAT_NS);
            check(!ram_busy, "R7 bus contention", ram_busy, 0);
        end
        if (!mem_we_n) begin
            we_low++;
            if (!mem_dq_oe || mem_ce_n) we_drv_ok = 0;
        end else if (we_low != 0) begin
            check(we_low >= WP_EXP, "R5 we pulse width", we_low, WP_EXP);
            check(we_drv_ok, "R5 drive during pulse", we_drv_ok, 1);
            check(mem_dq_oe, "R8 drive held after we rise", mem_dq_oe, 1);
            we_low = 0;
            we_drv_ok = 1;
        end
    end

    task automatic xfer(bit wr, logic [10:0] a, logic [7:0] d);
        int k;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        k = cyc;
        if (wr) ref_mem[int'(a)] = d;
        else begin
            exp_due.push_back(k + ACC_EXP);
            exp_dat.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
    endtask

    task automatic drain();
        while (exp_due.size() != 0 || !req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) ram[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(req_ready, "R1 ready in reset", req_ready, 1);
        check({mem_ce_n, mem_oe_n, mem_we_n} == 3'b111, "R1 strobes in reset",
              {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        check(!mem_dq_oe && !rd_valid, "R1 drive/valid in reset", {mem_dq_oe, rd_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && mem_ce_n && !mem_dq_oe, "R1 after reset",
              {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

        // R4 boundary addresses
        xfer(1, 11'h000, 8'h5A);
        xfer(1, 11'h7FF, 8'hC3);
        xfer(0, 11'h000, 8'h00);
        xfer(0, 11'h7FF, 8'h00);
        // R7 read directly followed by write, then read-read-write
        xfer(0, 11'h123, 8'h00);
        xfer(1, 11'h123, 8'hE1);
        xfer(0, 11'h123, 8'h00);
        xfer(0, 11'h7FF, 8'h00);
        xfer(1, 11'h400, 8'h3C);
        xfer(0, 11'h400, 8'h00);
        // R4 overwrite
        xfer(1, 11'h000, 8'hA5);
        xfer(0, 11'h000, 8'h00);
        drain();
        // R10: writes alone produce no rd_valid (monitor flags any)
        xfer(1, 11'h055, 8'h11);
        xfer(1, 11'h056, 8'h22);
        drain();
        // Random traffic
        for (int n = 0; n < 80; n++) begin
            logic [10:0] a;
            a = 11'($urandom_range(0, 2047));
            xfer(1, a, 8'($urandom));
            if (n % 3 == 0) xfer(0, 11'($urandom_range(0, 2047)), 8'h00);
            xfer(0, a, 8'h00);
        end
        drain();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule